// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block sits on the host side of a serial ADC that exchanges 16-bit frames over SPI. It runs a scan whenever a one-cycle trigger arrives. At that moment it captures the channel enable mask and then walks through the enabled channels from the lowest index to the highest. It sends one manual-mode conversion command for each enabled channel, followed by two zero frames. Chip select is released after every frame.

The converter answers two frames late. The sequencer throws away the first two words it receives in a scan. Each later word is matched with the channel that was commanded two frames earlier. The sequencer compares the channel tag in the upper nibble of the word against that channel, takes the sample field out of the word, and presents the result on a valid/ready stream. Each result carries its channel index, a last flag and a tag-error flag.

Back-pressure on the stream is applied between frames. While a result is waiting for the consumer, the next frame does not start, so SCLK stays idle and chip select stays high. A trigger that arrives while a scan is running is dropped and sets an overrun flag. A trigger with an empty mask finishes at once, with no SPI traffic.

Top module: `adc_scan_seq`

## Requirements
- R1: For each enabled channel the block sends one command word, lowest channel first. The word has bit 12 set (manual mode), the channel number in bits 10:7, and all other bits zero.
- R2: After the last channel command the block sends two all-zero frames, so one scan has exactly (enabled channels + 2) frames.
- R3: The words received in the first two frames of a scan are discarded. The word received in frame k+2 is emitted as the result for the channel commanded in frame k, in the same order.
- R4: Chip select (active low) rises after every 16-bit frame. SCLK idles low whenever chip select is high. MOSI is sent MSB first, and MISO is sampled on the rising SCLK edge.
- R5: Received bits 15:12 are compared with the expected channel. On a mismatch the result is still emitted, with `smp_tag_err_o` high.
- R6: The sample equals the received word shifted right by (12 − RES_BITS) and masked to RES_BITS bits, where RES_BITS is 8, 10 or 12.
- R7: The last result of a scan has `smp_last_o` high. `scan_done_o` pulses in the cycle after that result is accepted, and `busy_o` is then low.
- R8: A trigger with an all-zero mask pulses `scan_done_o` in the next cycle. It produces no frame and no result.
- R9: A trigger that arrives while `busy_o` is high is ignored and sets `overrun_o`. The flag stays set until the next trigger that is accepted.
- R10: While `smp_valid_o` is high and `smp_ready_i` is low, the result fields hold steady, no SCLK edge occurs, and chip select stays high.
- R11: After reset, chip select is high, SCLK is low, and valid, busy, done and overrun are all low.
- R12: The mask is captured at the accepted trigger. Changes to `chan_mask_i` during a scan have no effect on that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_trig_i | input | 1 | One-cycle scan start request |
| chan_mask_i | input | NUM_CH | Channel enable mask; bit i enables channel i |
| busy_o | output | 1 | A scan is in progress |
| scan_done_o | output | 1 | One-cycle pulse when a scan completes |
| overrun_o | output | 1 | A trigger was dropped during the current or last scan |
| spi_sclk_o | output | 1 | SPI clock, idle low |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | Command data to the converter |
| spi_miso_i | input | 1 | Result data from the converter |
| smp_valid_o | output | 1 | Result stream valid |
| smp_ready_i | input | 1 | Result stream ready |
| smp_data_o | output | RES_BITS | Extracted sample value |
| smp_chan_o | output | 4 | Channel the sample belongs to |
| smp_last_o | output | 1 | Final result of the scan |
| smp_tag_err_o | output | 1 | Returned channel tag did not match |

## Verification
The bench uses a converter model that answers every frame with the word for the channel commanded two frames earlier. It tests the following cases:
- **Misalignment.** A sequencer off by one frame would tag each sample with the wrong channel. It would also pick up the padding answers or lose the final sample.
- **Scan boundaries.** The bench runs a single channel, the top channel alone, sparse masks and all sixteen channels. Errors here would show up as missing or extra padding frames.
- **Tag errors.** A corrupted tag on one channel must raise only that sample's error flag. The scan must keep its length.
- **Control cases.** These cover a dropped mid-scan trigger, a mask changed during a scan, an empty mask, and a consumer that stalls. A design that restarts, re-reads the mask, emits phantom frames, or keeps clocking SCLK while a sample is waiting would change the frame count or the stalled outputs.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_W    = 16;
  localparam int TAG_W      = 4;
  localparam int TAG_LSB    = 12;
  localparam int CH_LSB     = 7;
  localparam int MANUAL_BIT = 12;
  localparam int PAD_FRAMES = 2;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LAUNCH,
    SQ_WAIT,
    SQ_PRESENT
  } seq_state_e;

  // Manual-mode conversion command for one channel
  function automatic logic [FRAME_W-1:0] build_cmd(input logic [TAG_W-1:0] ch);
    logic [FRAME_W-1:0] w;
    w = '0;
    w[MANUAL_BIT] = 1'b1;
    w[CH_LSB +: TAG_W] = ch;
    return w;
  endfunction
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] mask_i,
  output logic              any_o,
  output logic [3:0]        idx_o,
  output logic [NUM_CH-1:0] rest_o
);
  logic [NUM_CH-1:0] below;
  logic [NUM_CH-1:0] first;

  // below[i] is set when any lower channel is still pending
  always_comb begin
    below[0] = 1'b0;
    for (int i = 1; i < NUM_CH; i++) begin
      below[i] = below[i-1] | mask_i[i-1];
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_first
      assign first[g] = mask_i[g] & ~below[g];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (first[i]) idx_o = idx_o | 4'(i);
    end
  end

  assign any_o  = |mask_i;
  assign rest_o = mask_i & ~first;
endmodule

// File: rtl/adc_word_unpack.sv
module adc_word_unpack
  import adc_scan_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic [FRAME_W-1:0]  word_i,
  input  logic [TAG_W-1:0]    expect_ch_i,
  output logic [RES_BITS-1:0] data_o,
  output logic                tag_err_o
);
  localparam int SHIFT = TAG_LSB - RES_BITS;

  assign data_o    = word_i[SHIFT +: RES_BITS];
  assign tag_err_o = (word_i[TAG_LSB +: TAG_W] != expect_ch_i);
endmodule

// File: rtl/adc_spi_frame.sv
module adc_spi_frame #(
  parameter int FRAME_W  = 16,
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  output logic [FRAME_W-1:0] rx_word_o,
  output logic               done_o,
  output logic               sclk_o,
  output logic               cs_n_o,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  typedef enum logic [1:0] {FX_IDLE, FX_LOW, FX_HIGH, FX_GAP} fx_state_e;

  fx_state_e          st;
  logic [DIV_W-1:0]   div;
  logic [BIT_W-1:0]   bitn;
  logic [FRAME_W-1:0] tx_sh;
  logic [FRAME_W-1:0] rx_sh;
  logic               div_last;

  assign div_last = (div == DIV_W'(HALF_DIV - 1));
  assign mosi_o   = tx_sh[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FX_IDLE;
      div       <= '0;
      bitn      <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_word_o <= '0;
      done_o    <= 1'b0;
      sclk_o    <= 1'b0;
      cs_n_o    <= 1'b1;
    end else begin
      done_o <= 1'b0;
      case (st)
        FX_IDLE: begin
          if (start_i) begin
            tx_sh  <= tx_word_i;
            cs_n_o <= 1'b0;
            div    <= '0;
            bitn   <= '0;
            st     <= FX_LOW;
          end
        end
        FX_LOW: begin
          if (div_last) begin
            sclk_o <= 1'b1;
            rx_sh  <= {rx_sh[FRAME_W-2:0], miso_i};
            div    <= '0;
            st     <= FX_HIGH;
          end else begin
            div <= div + 1'b1;
          end
        end
        FX_HIGH: begin
          if (div_last) begin
            sclk_o <= 1'b0;
            div    <= '0;
            if (bitn == BIT_W'(FRAME_W - 1)) begin
              cs_n_o <= 1'b1;
              st     <= FX_GAP;
            end else begin
              tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
              bitn  <= bitn + 1'b1;
              st    <= FX_LOW;
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        default: begin
          if (div_last) begin
            done_o    <= 1'b1;
            rx_word_o <= rx_sh;
            div       <= '0;
            st        <= FX_IDLE;
          end else begin
            div <= div + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12,
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_trig_i,
  input  logic [NUM_CH-1:0]   chan_mask_i,
  output logic                busy_o,
  output logic                scan_done_o,
  output logic                overrun_o,
  output logic                spi_sclk_o,
  output logic                spi_cs_n_o,
  output logic                spi_mosi_o,
  input  logic                spi_miso_i,
  output logic                smp_valid_o,
  input  logic                smp_ready_i,
  output logic [RES_BITS-1:0] smp_data_o,
  output logic [3:0]          smp_chan_o,
  output logic                smp_last_o,
  output logic                smp_tag_err_o
);
  localparam int CNT_W = $clog2(NUM_CH + PAD_FRAMES + 1);

  seq_state_e         state;
  logic [NUM_CH-1:0]  rem;
  logic [CNT_W-1:0]   total;
  logic [CNT_W-1:0]   fidx;
  logic [CNT_W-1:0]   mask_cnt;
  logic [3:0]         pipe0, pipe1, pipe2;

  logic               pick_any;
  logic [3:0]         pick_idx;
  logic [NUM_CH-1:0]  pick_rest;
  logic [FRAME_W-1:0] tx_word;
  logic [FRAME_W-1:0] rx_word;
  logic               xfer_done;
  logic [RES_BITS-1:0] unp_data;
  logic               unp_err;

  always_comb begin
    mask_cnt = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      mask_cnt = mask_cnt + CNT_W'(chan_mask_i[i]);
    end
  end

  adc_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
    .mask_i (rem),
    .any_o  (pick_any),
    .idx_o  (pick_idx),
    .rest_o (pick_rest)
  );

  assign tx_word = pick_any ? build_cmd(pick_idx) : '0;

  adc_spi_frame #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (state == SQ_LAUNCH),
    .tx_word_i (tx_word),
    .rx_word_o (rx_word),
    .done_o    (xfer_done),
    .sclk_o    (spi_sclk_o),
    .cs_n_o    (spi_cs_n_o),
    .mosi_o    (spi_mosi_o),
    .miso_i    (spi_miso_i)
  );

  // pipe2 holds the channel commanded two frames before the current one
  adc_word_unpack #(.RES_BITS(RES_BITS)) u_unpack (
    .word_i      (rx_word),
    .expect_ch_i (pipe2),
    .data_o      (unp_data),
    .tag_err_o   (unp_err)
  );

  assign busy_o = (state != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= SQ_IDLE;
      rem           <= '0;
      total         <= '0;
      fidx          <= '0;
      pipe0         <= '0;
      pipe1         <= '0;
      pipe2         <= '0;
      smp_valid_o   <= 1'b0;
      smp_data_o    <= '0;
      smp_chan_o    <= '0;
      smp_last_o    <= 1'b0;
      smp_tag_err_o <= 1'b0;
      scan_done_o   <= 1'b0;
      overrun_o     <= 1'b0;
    end else begin
      scan_done_o <= 1'b0;
      if (scan_trig_i && (state != SQ_IDLE)) overrun_o <= 1'b1;
      case (state)
        SQ_IDLE: begin
          if (scan_trig_i) begin
            if (chan_mask_i == '0) begin
              scan_done_o <= 1'b1;
            end else begin
              rem       <= chan_mask_i;
              total     <= mask_cnt + CNT_W'(PAD_FRAMES);
              fidx      <= '0;
              overrun_o <= 1'b0;
              state     <= SQ_LAUNCH;
            end
          end
        end
        SQ_LAUNCH: begin
          if (pick_any) rem <= pick_rest;
          pipe2 <= pipe1;
          pipe1 <= pipe0;
          pipe0 <= pick_idx;
          state <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (xfer_done) begin
            if (fidx >= CNT_W'(PAD_FRAMES)) begin
              smp_valid_o   <= 1'b1;
              smp_data_o    <= unp_data;
              smp_tag_err_o <= unp_err;
              smp_chan_o    <= pipe2;
              smp_last_o    <= (fidx == total - CNT_W'(1));
              state         <= SQ_PRESENT;
            end else begin
              fidx  <= fidx + CNT_W'(1);
              state <= SQ_LAUNCH;
            end
          end
        end
        default: begin
          if (smp_ready_i) begin
            smp_valid_o <= 1'b0;
            if (smp_last_o) begin
              scan_done_o <= 1'b1;
              state       <= SQ_IDLE;
            end else begin
              fidx  <= fidx + CNT_W'(1);
              state <= SQ_LAUNCH;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scan_trig_i,
  input logic [NUM_CH-1:0]   chan_mask_i,
  input logic                busy_o,
  input logic                scan_done_o,
  input logic                overrun_o,
  input logic                spi_sclk_o,
  input logic                spi_cs_n_o,
  input logic                smp_valid_o,
  input logic                smp_ready_i,
  input logic [RES_BITS-1:0] smp_data_o,
  input logic [3:0]          smp_chan_o,
  input logic                smp_last_o,
  input logic                smp_tag_err_o
);
  // R10: a stalled result keeps its payload
  a_r10_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o && !smp_ready_i |=> smp_valid_o && $stable(smp_data_o) &&
      $stable(smp_chan_o) && $stable(smp_last_o) && $stable(smp_tag_err_o));

  // R10: no serial activity while a result waits
  a_r10_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o && !smp_ready_i |=> !spi_sclk_o && spi_cs_n_o);

  // R4: clock idles low whenever select is released
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sclk_o);

  // R4: select only drops inside a scan
  a_r4_cs_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n_o |-> busy_o);

  // R3: results are offered only between frames
  a_r3_valid_gap: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> spi_cs_n_o);

  // R7: done follows acceptance of the last result
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o && smp_ready_i && smp_last_o |=> scan_done_o && !busy_o);

  // R8: empty mask completes at once
  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    scan_trig_i && !busy_o && (chan_mask_i == '0) |=> scan_done_o && !busy_o);

  // R9: a trigger during a scan marks overrun
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    scan_trig_i && busy_o |=> overrun_o);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scan_trig_i   (scan_trig_i),
  .chan_mask_i   (chan_mask_i),
  .busy_o        (busy_o),
  .scan_done_o   (scan_done_o),
  .overrun_o     (overrun_o),
  .spi_sclk_o    (spi_sclk_o),
  .spi_cs_n_o    (spi_cs_n_o),
  .smp_valid_o   (smp_valid_o),
  .smp_ready_i   (smp_ready_i),
  .smp_data_o    (smp_data_o),
  .smp_chan_o    (smp_chan_o),
  .smp_last_o    (smp_last_o),
  .smp_tag_err_o (smp_tag_err_o)
);

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
module adc_scan_seq_bench;
  localparam int NCH = 16;
  localparam int RES = 10;
  localparam int IW  = RES + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_trig = 1'b0;
  logic [NCH-1:0] chan_mask = '0;
  logic busy, done, overrun, sclk, cs_n, mosi;
  logic miso = 1'b0;
  logic valid;
  logic ready = 1'b1;
  logic [RES-1:0] sdata;
  logic [3:0] schan;
  logic slast, serr;

  int errors = 0;
  int checks = 0;
  int frame_cnt = 0;
  int done_cnt = 0;
  int sclk_rises = 0;
  int seed_v = 0;
  int corrupt_v = -1;
  int frames_at_start = 0;
  int done_at_start = 0;
  bit rdy_force_en = 1'b0;
  bit rdy_force_val = 1'b1;
  bit exp_done_next = 1'b0;
  logic [7:0] lfsr = 8'h5b;
  logic [15:0] cmd_q[$];
  logic [IW-1:0] samp_q[$];

  always #2.5 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NCH), .RES_BITS(RES), .HALF_DIV(2)) u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .scan_trig_i(scan_trig), .chan_mask_i(chan_mask),
    .busy_o(busy), .scan_done_o(done), .overrun_o(overrun),
    .spi_sclk_o(sclk), .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .smp_valid_o(valid), .smp_ready_i(ready), .smp_data_o(sdata),
    .smp_chan_o(schan), .smp_last_o(slast), .smp_tag_err_o(serr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mkval(input int ch, input int seed);
    return 12'(ch * 263 + seed * 29 + 5);
  endfunction

  // Converter model: answers each frame with the word for the command two frames back
  initial begin
    logic [15:0] resp;
    logic [15:0] rcmd;
    logic [15:0] ecmd;
    logic [3:0] hist_a, hist_b, tag;
    hist_a = '0;
    hist_b = '0;
    forever begin
      @(negedge cs_n);
      tag = (int'(hist_b) == corrupt_v) ? ~hist_b : hist_b;
      resp = {tag, mkval(int'(hist_b), seed_v)};
      miso = resp[15];
      rcmd = '0;
      for (int i = 0; i < 16; i++) begin
        @(posedge sclk);
        rcmd = {rcmd[14:0], mosi};
        @(negedge sclk);
        if (i < 15) miso = resp[14-i];
      end
      frame_cnt++;
      if (cmd_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected frame command", rcmd, 0);
      end else begin
        ecmd = cmd_q.pop_front();
        chk(rcmd == ecmd, (ecmd == 16'h0) ? "R2" : "R1", "command word", rcmd, ecmd);
      end
      hist_b = hist_a;
      hist_a = rcmd[10:7];
    end
  end

  always @(posedge sclk) sclk_rises++;

  // Ready driver: changes away from both clock edges
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ready = rdy_force_en ? rdy_force_val : (lfsr[0] | lfsr[2]);
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (exp_done_next) begin
        chk(done == 1'b1, "R7", "done pulse after last accept", done, 1);
        exp_done_next = 1'b0;
      end
      if (valid && ready) begin
        if (samp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected result", {serr, slast, schan, sdata}, 0);
        end else begin
          logic [IW-1:0] e;
          e = samp_q.pop_front();
          chk({serr, slast, schan, sdata} == e, "R3 R5 R6 R7", "result {err,last,chan,data}",
              {serr, slast, schan, sdata}, e);
          if (e[RES+4]) exp_done_next = 1'b1;
        end
      end
    end
  end

  task automatic start_scan(input logic [NCH-1:0] m, input int seed, input int corrupt);
    int n;
    int k;
    logic [11:0] raw;
    n = $countones(m);
    k = 0;
    seed_v = seed;
    corrupt_v = corrupt;
    for (int ch = 0; ch < NCH; ch++) begin
      if (m[ch]) begin
        cmd_q.push_back(16'h1000 | 16'(ch << 7));
        raw = mkval(ch, seed);
        samp_q.push_back({(ch == corrupt), (k == n - 1), 4'(ch), raw[11 -: RES]});
        k++;
      end
    end
    if (n != 0) begin
      cmd_q.push_back(16'h0);
      cmd_q.push_back(16'h0);
    end
    frames_at_start = frame_cnt;
    done_at_start = done_cnt;
    @(negedge clk);
    chan_mask = m;
    scan_trig = 1'b1;
    @(negedge clk);
    scan_trig = 1'b0;
  endtask

  task automatic finish_scan(input int exp_frames);
    while (done_cnt == done_at_start) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(frame_cnt - frames_at_start == exp_frames, "R2", "frames in scan",
        frame_cnt - frames_at_start, exp_frames);
    chk(samp_q.size() == 0, "R3", "results left undelivered", samp_q.size(), 0);
    chk(cmd_q.size() == 0, "R1", "commands left unsent", cmd_q.size(), 0);
  endtask

  task automatic run_scan(input logic [NCH-1:0] m, input int seed, input int corrupt);
    start_scan(m, seed, corrupt);
    finish_scan($countones(m) + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7", "watchdog: scan never completed", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int fc, sr, dc;
    logic [RES-1:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1, "R11", "cs_n after reset", cs_n, 1);
    chk(sclk == 1'b0, "R11", "sclk after reset", sclk, 0);
    chk(valid == 1'b0, "R11", "valid after reset", valid, 0);
    chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
    chk(overrun == 1'b0 && done == 1'b0, "R11", "flags after reset", {overrun, done}, 0);

    // R1 R3 R6: single, sparse, full, top-only masks
    run_scan(16'h0001, 1, -1);
    run_scan(16'h8421, 2, -1);
    run_scan(16'hFFFF, 3, -1);
    run_scan(16'h8000, 4, -1);

    // R5: channel 5 answers with a wrong tag
    run_scan(16'h0C30, 5, 5);

    // R8: empty mask
    fc = frame_cnt;
    sr = sclk_rises;
    dc = done_cnt;
    @(negedge clk);
    chan_mask = '0;
    scan_trig = 1'b1;
    @(negedge clk);
    scan_trig = 1'b0;
    chk(done == 1'b1, "R8", "done pulse on empty mask", done, 1);
    chk(busy == 1'b0, "R8", "busy on empty mask", busy, 0);
    repeat (20) @(negedge clk);
    chk(frame_cnt == fc && sclk_rises == sr, "R8", "serial edges on empty mask",
        sclk_rises - sr, 0);
    chk(done_cnt == dc + 1, "R8", "done count on empty mask", done_cnt - dc, 1);

    // R9: trigger during a scan is dropped
    start_scan(16'h00F0, 6, -1);
    repeat (20) @(negedge clk);
    chan_mask = 16'hFFFF;
    scan_trig = 1'b1;
    @(negedge clk);
    scan_trig = 1'b0;
    @(negedge clk);
    chk(overrun == 1'b1, "R9", "overrun after busy trigger", overrun, 1);
    finish_scan(6);
    chk(overrun == 1'b1, "R9", "overrun held after scan", overrun, 1);
    start_scan(16'h0100, 7, -1);
    @(negedge clk);
    chk(overrun == 1'b0, "R9", "overrun cleared by accepted trigger", overrun, 0);
    finish_scan(3);

    // R12: mask change mid-scan has no effect
    start_scan(16'h0505, 8, -1);
    repeat (3) @(negedge clk);
    chan_mask = 16'hFFFF;
    finish_scan(6);

    // R10: stalled consumer freezes the bus
    rdy_force_en = 1'b1;
    rdy_force_val = 1'b0;
    #0;
    start_scan(16'h0006, 9, -1);
    while (!valid) @(negedge clk);
    held = sdata;
    sr = sclk_rises;
    repeat (40) @(negedge clk);
    chk(valid == 1'b1 && sdata == held, "R10", "stalled result data", sdata, held);
    chk(sclk_rises == sr, "R10", "sclk rises during stall", sclk_rises - sr, 0);
    chk(cs_n == 1'b1, "R10 R4", "cs_n during stall", cs_n, 1);
    rdy_force_en = 1'b0;
    finish_scan(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule